// File: doc/BRIEF.md
# Dual-Plane Burst Read Serializer

This block connects two 16-bit storage planes, which are read side by side, to a 16-bit host read port. When a page starts, the sequencer waits out the slow array access time. It then fetches from both planes at once with an internal read strobe. Each fetch places one 32-bit pair in a small FIFO: the plane 0 word sits in the low half and the plane 1 word in the high half.

The host pulls data with its own output-enable strobe. Each strobe takes one 16-bit half of the oldest FIFO entry, the plane 0 half first. Only the first word of a page waits for the array. After that the sequencer prefetches whenever a FIFO slot is free, so the rate of the host strobe sets the throughput.

A ready output shows that data is waiting. A strobe that arrives while nothing is waiting is ignored and marked in a sticky underrun flag. When the last word of the page has been delivered, a page-done flag rises.

Top module: `dualPlaneBurstReader`

## Requirements
- R1: While reset is asserted and after it is released, with no page started, hostData, ready, underrun, pageDone and planeOe are all 0.
- R2: Each cycle with planeOe high captures plane0Data and plane1Data for entry planeAddr into the FIFO. The entry holds plane 0 in bits 15:0 and plane 1 in bits 31:16. Ready is high in the cycle after a fetch.
- R3: Host word k of a page (k counted from 0) is the plane 0 word of entry k/2 when k is even and the plane 1 word of entry k/2 when k is odd. Entries are fetched in increasing planeAddr from 0.
- R4: Ready rises exactly ACCESS_LAT+1 clock edges after the edge that samples pageStart. planeOe stays low for the first ACCESS_LAT cycles after that edge.
- R5: planeOe is asserted whenever the FIFO has a free slot and entries of the page remain. With the host idle, exactly FIFO_DEPTH fetches happen, and then fetching stops.
- R6: Once ready is high, a host strobe in every cycle reads the whole page with ready never dropping.
- R7: A host strobe while ready is low leaves hostData unchanged and sets underrun. Underrun then stays set until the next pageStart.
- R8: hostData changes only on the edge that samples an accepted strobe (hostOe high with ready high and pageStart low).
- R9: After PAGE_WORDS words have been delivered, pageDone is 1 and ready is 0. By then exactly PAGE_WORDS/2 fetches have been made, and no further planeOe occurs.
- R10: pageStart, even in the middle of a page, empties the FIFO, clears pageDone and underrun, and restarts at word 0. It takes priority over a host strobe in the same cycle, which is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageStart | input | 1 | One-cycle pulse that begins a new page |
| hostOe | input | 1 | Host read strobe, one word per high cycle |
| plane0Data | input | 16 | Plane 0 word at planeAddr |
| plane1Data | input | 16 | Plane 1 word at planeAddr |
| planeOe | output | 1 | Internal fetch strobe to both planes |
| planeAddr | output | ADDR_W | Entry index in the page being fetched |
| hostData | output | 16 | Registered host read data |
| ready | output | 1 | FIFO holds data for the host |
| underrun | output | 1 | Sticky flag for strobes ignored while not ready |
| pageDone | output | 1 | All words of the page delivered |

## Verification
The bench builds the block with a 16-word page and a 5-cycle array access time, and keeps the default 4-entry FIFO. With these values a page boundary, its done flag and the end of fetching are reached many times in a short run. The FIFO can be filled completely while the host is idle, and the exact first-word latency can be counted edge by edge. Random host strobe densities are mixed with directed cases: a strobe before ready, a continuous back-to-back read, and a restart in the middle of a page that coincides with a host strobe.

// File: rtl/dpbPkg.sv
package dpbPkg;
  typedef struct packed {
    logic flush;
    logic push;
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SENSE,
    SEQ_STREAM,
    SEQ_DONE
  } seqStateT;
endpackage

// File: rtl/dpbSeqCtrl.sv
module dpbSeqCtrl
  import dpbPkg::*;
#(
  parameter int ACCESS_LAT = 8,
  parameter int ENTRIES    = 128,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageStart,
  input  logic              fifoFull,
  output logic              planeOe,
  output logic [ADDR_W-1:0] planeAddr,
  output ctrlStrobeT        strobes
);
  localparam int LAT_W = $clog2(ACCESS_LAT + 1);

  seqStateT          state;
  logic [LAT_W-1:0]  latCnt;
  logic [ADDR_W-1:0] fetchCnt;
  logic              fetchNow;

  // A fetch happens only while streaming, with room in the FIFO, and not on a restart.
  assign fetchNow      = (state == SEQ_STREAM) && !fifoFull && !pageStart;
  assign planeOe       = fetchNow;
  assign planeAddr     = fetchCnt;
  assign strobes.flush = pageStart;
  assign strobes.push  = fetchNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      latCnt   <= '0;
      fetchCnt <= '0;
    end else if (pageStart) begin
      state    <= SEQ_SENSE;
      latCnt   <= LAT_W'(ACCESS_LAT);
      fetchCnt <= '0;
    end else begin
      unique case (state)
        SEQ_SENSE: begin
          // Slow array access: only the first fetch of a page waits here.
          if (latCnt == LAT_W'(1)) state <= SEQ_STREAM;
          latCnt <= latCnt - LAT_W'(1);
        end
        SEQ_STREAM: begin
          if (fetchNow) begin
            if (fetchCnt == ADDR_W'(ENTRIES - 1)) state <= SEQ_DONE;
            else fetchCnt <= fetchCnt + ADDR_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dpbPairFifo.sv
module dpbPairFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dpbDataPath.sv
module dpbDataPath
  import dpbPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int PAGE_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [DATA_W-1:0] plane0Data,
  input  logic [DATA_W-1:0] plane1Data,
  input  logic              hostOe,
  output logic              fifoFull,
  output logic [DATA_W-1:0] hostData,
  output logic              ready,
  output logic              underrun,
  output logic              pageDone
);
  localparam int ENTRY_W = 2 * DATA_W;
  localparam int WCNT_W  = $clog2(PAGE_WORDS);

  logic [ENTRY_W-1:0] wrEntry, rdEntry;
  logic               fifoEmpty, accept, halfSel, pop;
  logic [WCNT_W-1:0]  wordCnt;
  logic [DATA_W-1:0]  muxWord;

  // Plane 0 fills the low half, plane 1 the high half of an entry.
  assign wrEntry = {plane1Data, plane0Data};

  dpbPairFifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (strobes.flush),
    .push   (strobes.push),
    .wrData (wrEntry),
    .pop    (pop),
    .rdData (rdEntry),
    .empty  (fifoEmpty),
    .full   (fifoFull)
  );

  assign ready   = !fifoEmpty;
  assign accept  = hostOe && !fifoEmpty && !strobes.flush;
  assign pop     = accept && halfSel;
  assign muxWord = halfSel ? rdEntry[ENTRY_W-1:DATA_W] : rdEntry[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) hostData <= '0;
    else if (accept) hostData <= muxWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      halfSel  <= 1'b0;
      wordCnt  <= '0;
      pageDone <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (accept) begin
        halfSel <= !halfSel;
        wordCnt <= wordCnt + WCNT_W'(1);
        if (wordCnt == WCNT_W'(PAGE_WORDS - 1)) pageDone <= 1'b1;
      end
      if (hostOe && fifoEmpty) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/dualPlaneBurstReader.sv
module dualPlaneBurstReader
  import dpbPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ACCESS_LAT = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int PAGE_WORDS = 256,
  localparam int ENTRIES   = PAGE_WORDS / 2,
  localparam int ADDR_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageStart,
  input  logic              hostOe,
  input  logic [DATA_W-1:0] plane0Data,
  input  logic [DATA_W-1:0] plane1Data,
  output logic              planeOe,
  output logic [ADDR_W-1:0] planeAddr,
  output logic [DATA_W-1:0] hostData,
  output logic              ready,
  output logic              underrun,
  output logic              pageDone
);
  ctrlStrobeT strobes;
  logic       fifoFull;

  dpbSeqCtrl #(.ACCESS_LAT(ACCESS_LAT), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pageStart (pageStart),
    .fifoFull  (fifoFull),
    .planeOe   (planeOe),
    .planeAddr (planeAddr),
    .strobes   (strobes)
  );

  dpbDataPath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .PAGE_WORDS(PAGE_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .plane0Data (plane0Data),
    .plane1Data (plane1Data),
    .hostOe     (hostOe),
    .fifoFull   (fifoFull),
    .hostData   (hostData),
    .ready      (ready),
    .underrun   (underrun),
    .pageDone   (pageDone)
  );
endmodule

// File: rtl/dpbChecker.sv
module dpbChecker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pageStart,
  input logic              hostOe,
  input logic              planeOe,
  input logic [DATA_W-1:0] hostData,
  input logic              ready,
  input logic              underrun,
  input logic              pageDone
);
  // R2
  fetch_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    planeOe && !pageStart |=> ready);

  // R4
  restart_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageStart |=> !ready && !planeOe);

  // R7
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostOe && !ready && !pageStart |=> underrun);

  // R7
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !pageStart |=> underrun);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hostOe && ready && !pageStart) |=> $stable(hostData));

  // R9
  no_fetch_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageDone |-> !planeOe && !ready);

  // R10
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageStart |=> !underrun && !pageDone);
endmodule

bind dualPlaneBurstReader dpbChecker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pageStart (pageStart),
  .hostOe    (hostOe),
  .planeOe   (planeOe),
  .hostData  (hostData),
  .ready     (ready),
  .underrun  (underrun),
  .pageDone  (pageDone)
);

// File: tb/dualPlaneBurstReader_bench.sv
`timescale 1ns/1ps
module dualPlaneBurstReader_bench;
  localparam int DW    = 16;
  localparam int LAT   = 5;
  localparam int DEPTH = 4;
  localparam int PW    = 16;
  localparam int ENT   = PW / 2;
  localparam int AW    = $clog2(ENT);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pageStart = 1'b0;
  logic          hostOe = 1'b0;
  logic [DW-1:0] plane0Data, plane1Data;
  logic          planeOe, ready, underrun, pageDone;
  logic [AW-1:0] planeAddr;
  logic [DW-1:0] hostData;

  int            checks = 0;
  int            fails = 0;
  int            expIdx = 0;
  int            fetches = 0;
  bit            expUnder = 0;
  logic [DW-1:0] pageSeed = 16'h1357;

  always #10 clk = ~clk;

  dualPlaneBurstReader #(.DATA_W(DW), .ACCESS_LAT(LAT), .FIFO_DEPTH(DEPTH), .PAGE_WORDS(PW))
    u_dualPlaneBurstReader (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .hostOe(hostOe),
    .plane0Data(plane0Data), .plane1Data(plane1Data), .planeOe(planeOe),
    .planeAddr(planeAddr), .hostData(hostData), .ready(ready),
    .underrun(underrun), .pageDone(pageDone));

  function automatic logic [DW-1:0] p0f(input int a);
    return DW'(a * 307) ^ pageSeed;
  endfunction
  function automatic logic [DW-1:0] p1f(input int a);
    return ~DW'(a * 2567) ^ pageSeed;
  endfunction
  function automatic logic [DW-1:0] wordVal(input int k);
    return (k % 2 == 0) ? p0f(k / 2) : p1f(k / 2);
  endfunction

  // Storage plane model
  always_comb begin
    plane0Data = p0f(int'(planeAddr));
    plane1Data = p1f(int'(planeAddr));
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic ps, input logic oe);
    logic          rdyBefore;
    logic [DW-1:0] prevData;
    pageStart = ps;
    hostOe    = oe;
    #1;
    rdyBefore = ready;
    prevData  = hostData;
    if (planeOe) begin
      chk(planeAddr == AW'(fetches), "R3 fetch order", planeAddr, fetches);
      fetches++;
    end
    @(posedge clk);
    #1;
    pageStart = 1'b0;
    hostOe    = 1'b0;
    if (ps) begin
      chk(hostData == prevData, "R10 strobe ignored on restart", hostData, prevData);
      chk(!underrun && !pageDone, "R10 flags cleared", {underrun, pageDone}, 0);
      expIdx = 0; fetches = 0; expUnder = 0;
    end else if (oe && rdyBefore) begin
      chk(hostData == wordVal(expIdx), "R3 word order", hostData, wordVal(expIdx));
      expIdx++;
    end else begin
      chk(hostData == prevData, "R8 data held", hostData, prevData);
      if (oe) expUnder = 1;
    end
    chk(underrun == expUnder, "R7 underrun", underrun, expUnder);
    chk(pageDone == (expIdx == PW), "R9 done flag", pageDone, expIdx == PW);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk({hostData, ready, underrun, pageDone, planeOe} == '0, "R1 in reset",
        {hostData, ready, underrun, pageDone, planeOe}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk({hostData, ready, underrun, pageDone, planeOe} == '0, "R1 after reset",
        {hostData, ready, underrun, pageDone, planeOe}, 0);

    // R4 first-word latency, with an early strobe (R7)
    step(1, 0);
    for (int j = 1; j <= LAT + 1; j++) begin
      step(0, j == 2);
      chk(ready == (j == LAT + 1), "R4 ready timing", ready, j == LAT + 1);
      chk(fetches == ((j == LAT + 1) ? 1 : 0), "R4 no early fetch", fetches, (j == LAT + 1) ? 1 : 0);
    end
    chk(underrun == 1'b1, "R7 early strobe flagged", underrun, 1);

    // R5 prefetch fills the FIFO and stops
    for (int j = 0; j < 6; j++) step(0, 0);
    chk(fetches == DEPTH, "R5 prefetch count", fetches, DEPTH);
    chk(ready == 1'b1, "R2 ready after fetch", ready, 1);

    // R6 back-to-back read of the whole page
    for (int j = 0; j < PW; j++) begin
      #1;
      chk(ready == 1'b1, "R6 no stall", ready, 1);
      step(0, 1);
    end
    chk(fetches == ENT, "R9 fetch total", fetches, ENT);
    chk(ready == 1'b0, "R9 ready low at end", ready, 0);
    for (int j = 0; j < 3; j++) step(0, 0);
    chk(fetches == ENT, "R9 no fetch after end", fetches, ENT);
    chk(underrun == 1'b1, "R7 sticky", underrun, 1);

    // Random pages, with a restart mid-page on the second one (R10)
    for (int pg = 0; pg < 4; pg++) begin
      int pct = 20 + pg * 25;
      int guard = 0;
      bit restarted = 0;
      pageSeed = DW'($urandom);
      step(1, 0);
      while (expIdx < PW && guard < 2000) begin
        if (pg == 1 && !restarted && expIdx == 5) begin
          while (!ready) step(0, 0);
          step(1, 1);
          restarted = 1;
          chk(expIdx == 0, "R10 restart at word 0", expIdx, 0);
        end else begin
          step(0, ($urandom % 100) < pct);
        end
        guard++;
      end
      chk(pageDone == 1'b1, "R9 random page done", pageDone, 1);
      chk(fetches == ENT, "R9 random fetch total", fetches, ENT);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule